// File: doc/BRIEF.md
# Streaming Extreme-Element Index Finder

The block scans a vector of floating-point words that arrives one element per handshake beat and reports where its extreme element sits. The result is both the 1-based position and the word itself. A single start strobe loads the vector length and two mode bits. The first mode bit picks whether the largest or the smallest element is sought. The second picks whether elements are ordered by magnitude, ignoring the sign, or by signed value.

Elements are consumed at one per clock with no stall. A strictly-beyond comparison drives a plain select, so the running winner is replaced only by a value that truly exceeds it. Among equal candidates the earliest position wins. Position is tracked with a down-counter loaded from the length. The run ends on the beat carrying the last flag, or on the beat that exhausts the length, whichever comes first. A one-cycle done pulse then marks the result, which stays on the outputs until the next run completes.

Word width is a parameter, either single (32-bit) or double (64-bit) IEEE-754-style words. NaN inputs, denormal-specific handling and multi-lane reduction are not part of the block.

Top module: `xtrm_index_finder`

## Requirements
- R1: After reset, in_ready is 0, res_done is 0, and res_index and res_value are both 0.
- R2: A start strobe loads length, sel_min and sel_signed. With a nonzero length, in_ready is 1 from the cycle after start. Start has priority over a beat in the same cycle and abandons any run in progress without a done pulse.
- R3: A beat is taken on each clock where in_valid and in_ready are both 1. Cycles with in_valid at 0 change nothing.
- R4: The first element taken seeds the running extreme. If no later element beats it, res_index is 1.
- R5: The running extreme and its position are replaced only by an element strictly beyond it. On equal values the earliest position is kept.
- R6: With sel_signed=0, elements are ordered by bits [W-2:0] read as an unsigned integer, so the sign bit (bit W-1) is ignored. res_value returns the chosen element with its original sign.
- R7: With sel_signed=1, any word with bit W-1 set is below any word with it clear. Among two such negative words, the one with larger bits [W-2:0] is the smaller.
- R8: sel_min=0 seeks the largest element and sel_min=1 seeks the smallest.
- R9: The run ends on the taken beat with in_last=1, or on the taken beat numbered length, whichever comes first. res_done is 1 for exactly the one following cycle, and res_index is the 1-based position of the winner.
- R10: in_ready is 0 from the cycle after the final beat until the next start, and also before the first start.
- R11: A start with length 0 takes no beats and gives res_done in the following cycle, with res_index 0 and res_value 0.
- R12: res_index and res_value change only in a cycle where res_done is 1, and hold between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new run; loads length and modes |
| length | input | LEN_W | Number of elements in the run |
| sel_min | input | 1 | 1 seeks the smallest element, 0 the largest |
| sel_signed | input | 1 | 1 orders by signed value, 0 by magnitude |
| in_valid | input | 1 | Element beat is present |
| in_ready | output | 1 | Block accepts an element this cycle |
| in_data | input | W | Element word |
| in_last | input | 1 | Marks the final element of the run |
| res_done | output | 1 | One-cycle pulse: result is fresh |
| res_index | output | LEN_W | 1-based position of the extreme element, 0 for empty run |
| res_value | output | W | Extreme element word |

## Verification
A wrong winner register or captured counter value shows up only at the done pulse, as a wrong res_index or res_value. Faults in the comparison ordering, tie rule or mode latching therefore surface one cycle after the final beat, and not before. Faults in the run state are visible at once as a wrong in_ready level, or as a missing, early or doubled done pulse in the cycle after the ending beat. The reference model compares ready, done and both result fields on every clock. A disturbed hold shows as a result change outside a done cycle.

// File: rtl/xtrm_pkg.sv
package xtrm_pkg;
   localparam int SGL_W = 32;
   localparam int DBL_W = 64;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_HOLD = 2'd2
   } xtrm_state_e;

   function automatic int word_width(input bit use_double);
      return use_double ? DBL_W : SGL_W;
   endfunction
endpackage

// File: rtl/xtrm_order_key.sv
// Maps an element word to an unsigned key whose integer order equals the
// element order for the selected mode.
module xtrm_order_key #(
   parameter int W = 32
) (
   input  logic [W-1:0] word,
   input  logic         signed_mode,
   output logic [W-1:0] key
);
   localparam int MSB = W - 1;

   logic [W-1:0] mag_key;
   logic [W-1:0] sgn_key;

   always_comb begin
      mag_key = {1'b0, word[MSB-1:0]};
      // negatives: invert so larger magnitude sorts lower; positives: lift above
      if (word[MSB]) sgn_key = ~word;
      else           sgn_key = {1'b1, word[MSB-1:0]};
      key = signed_mode ? sgn_key : mag_key;
   end
endmodule

// File: rtl/xtrm_better.sv
// Strict "beyond" test between a candidate key and the running key.
module xtrm_better #(
   parameter int W = 32
) (
   input  logic [W-1:0] cand_key,
   input  logic [W-1:0] cur_key,
   input  logic         seek_min,
   output logic         beyond
);
   logic above;
   logic below;

   always_comb begin
      above  = cand_key > cur_key;
      below  = cand_key < cur_key;
      beyond = seek_min ? below : above;
   end
endmodule

// File: rtl/xtrm_position.sv
// Down-counter of remaining elements in the current run.
module xtrm_position #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_len,
   input  logic             step,
   output logic [LEN_W-1:0] remain,
   output logic             on_final
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    remain <= '0;
      else if (load) remain <= load_len;
      else if (step) remain <= remain - ONE;
   end

   assign on_final = (remain == ONE);
endmodule

// File: rtl/xtrm_index_finder.sv
module xtrm_index_finder #(
   parameter int LEN_W      = 8,
   parameter bit USE_DOUBLE = 1'b0,
   localparam int W         = xtrm_pkg::word_width(USE_DOUBLE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] length,
   input  logic             sel_min,
   input  logic             sel_signed,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [W-1:0]     in_data,
   input  logic             in_last,
   output logic             res_done,
   output logic [LEN_W-1:0] res_index,
   output logic [W-1:0]     res_value
);
   import xtrm_pkg::*;

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   generate
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("xtrm_index_finder: LEN_W must lie in 1..32");
      end
      if (W != SGL_W && W != DBL_W) begin : g_bad_width
         $error("xtrm_index_finder: word width must be 32 or 64");
      end
   endgenerate

   xtrm_state_e      state_q;
   logic             min_q;
   logic             sgn_q;
   logic [LEN_W-1:0] len_q;
   logic [W-1:0]     best_q;
   logic [LEN_W-1:0] best_rem_q;
   logic             done_q;
   logic [LEN_W-1:0] idx_q;
   logic [W-1:0]     val_q;

   logic [LEN_W-1:0] remain;
   logic             on_final;
   logic [W-1:0]     cand_key;
   logic [W-1:0]     cur_key;
   logic             beyond;
   logic             take;
   logic             first;
   logic             adopt;
   logic             finish;
   logic [LEN_W-1:0] rem_after;

   assign in_ready  = (state_q == ST_SCAN);
   assign take      = in_valid && in_ready && !start;
   assign first     = (remain == len_q);
   assign adopt     = take && (first || beyond);
   assign finish    = take && (in_last || on_final);
   assign rem_after = remain - ONE;

   xtrm_position #(.LEN_W(LEN_W)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_len (length),
      .step     (take),
      .remain   (remain),
      .on_final (on_final)
   );

   xtrm_order_key #(.W(W)) u_key_cand (
      .word        (in_data),
      .signed_mode (sgn_q),
      .key         (cand_key)
   );

   xtrm_order_key #(.W(W)) u_key_cur (
      .word        (best_q),
      .signed_mode (sgn_q),
      .key         (cur_key)
   );

   xtrm_better #(.W(W)) u_cmp (
      .cand_key (cand_key),
      .cur_key  (cur_key),
      .seek_min (min_q),
      .beyond   (beyond)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         min_q      <= 1'b0;
         sgn_q      <= 1'b0;
         len_q      <= '0;
         best_q     <= '0;
         best_rem_q <= '0;
         done_q     <= 1'b0;
         idx_q      <= '0;
         val_q      <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            min_q <= sel_min;
            sgn_q <= sel_signed;
            len_q <= length;
            if (length == '0) begin
               state_q <= ST_HOLD;
               done_q  <= 1'b1;
               idx_q   <= '0;
               val_q   <= '0;
            end else begin
               state_q <= ST_SCAN;
            end
         end else if (take) begin
            if (adopt) begin
               best_q     <= in_data;
               best_rem_q <= rem_after;
            end
            if (finish) begin
               state_q <= ST_HOLD;
               done_q  <= 1'b1;
               val_q   <= adopt ? in_data : best_q;
               idx_q   <= len_q - (adopt ? rem_after : best_rem_q);
            end
         end
      end
   end

   assign res_done  = done_q;
   assign res_index = idx_q;
   assign res_value = val_q;
endmodule

// File: rtl/xtrm_checker.sv
module xtrm_checker #(
   parameter int LEN_W = 8,
   parameter int W     = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [LEN_W-1:0] length,
   input logic             in_valid,
   input logic             in_ready,
   input logic             res_done,
   input logic [LEN_W-1:0] res_index,
   input logic [W-1:0]     res_value
);
   logic [LEN_W:0] beats_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                            beats_q <= '0;
      else if (start)                        beats_q <= '0;
      else if (in_valid && in_ready)         beats_q <= beats_q + 1'b1;
   end

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_done && !(start && length == '0) |=> !res_done);

   assert_index_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> ({1'b0, res_index} <= beats_q));

   assert_ready_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> !in_ready);

   assert_ready_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(start));

   assert_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      res_done && beats_q == '0 |-> res_index == '0 && res_value == '0);

   assert_seeded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_done && beats_q != '0 |-> res_index != '0);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_index) || !$stable(res_value) |-> res_done);
endmodule

bind xtrm_index_finder xtrm_checker #(.LEN_W(LEN_W), .W(W)) u_xtrm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .length    (length),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .res_done  (res_done),
   .res_index (res_index),
   .res_value (res_value)
);

// File: tb/xtrm_index_finder_bench.sv
`timescale 1ns/1ps
module xtrm_index_finder_bench;
   localparam int LEN_W = 8;
   localparam int W     = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LEN_W-1:0] length = '0;
   logic             sel_min = 1'b0;
   logic             sel_signed = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [W-1:0]     in_data = '0;
   logic             in_last = 1'b0;
   logic             res_done;
   logic [LEN_W-1:0] res_index;
   logic [W-1:0]     res_value;

   int errors = 0;
   int checks = 0;
   int done_seen = 0;
   logic [W-1:0] vec [0:255];

   always #2.5 clk = ~clk;

   xtrm_index_finder #(.LEN_W(LEN_W), .USE_DOUBLE(1'b0)) u_xtrm_index_finder (
      .clk, .rst_n, .start, .length, .sel_min, .sel_signed,
      .in_valid, .in_ready, .in_data, .in_last,
      .res_done, .res_index, .res_value
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // a strictly beyond b under the given modes
   function automatic bit beats(input logic [W-1:0] a, input logic [W-1:0] b,
                                input bit mn, input bit sg);
      bit gt, lt;
      if (!sg || (a[W-1] == 1'b0 && b[W-1] == 1'b0)) begin
         gt = a[W-2:0] > b[W-2:0];
         lt = a[W-2:0] < b[W-2:0];
      end else if (a[W-1] != b[W-1]) begin
         gt = b[W-1];
         lt = a[W-1];
      end else begin
         gt = a[W-2:0] < b[W-2:0];
         lt = a[W-2:0] > b[W-2:0];
      end
      return mn ? lt : gt;
   endfunction

   // behavioural reference model, advanced at each rising edge
   bit           m_run;
   int           m_len, m_n, m_idx;
   bit           m_min, m_sgn;
   logic [W-1:0] m_best;
   bit           e_done;
   int           e_idx;
   logic [W-1:0] e_val;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_len = 0; m_n = 0; m_idx = 0; m_best = '0;
         e_done = 0; e_idx = 0; e_val = '0;
      end else begin
         e_done = 0;
         if (start) begin
            m_len = int'(length); m_n = 0; m_min = sel_min; m_sgn = sel_signed;
            m_run = (length != 0);
            if (length == 0) begin e_done = 1; e_idx = 0; e_val = '0; end
         end else if (m_run && in_valid) begin
            m_n++;
            if (m_n == 1 || beats(in_data, m_best, m_min, m_sgn)) begin
               m_best = in_data; m_idx = m_n;
            end
            if (in_last || m_n == m_len) begin
               m_run = 0; e_done = 1; e_idx = m_idx; e_val = m_best;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R10 in_ready", in_ready, m_run);
         chk("R9 res_done", res_done, e_done);
         chk("R12 res_index", res_index, e_idx);
         chk("R12 res_value", res_value, e_val);
         if (res_done) done_seen++;
      end
   end

   task automatic run(input int nb, input int len, input bit mn, input bit sg,
                      input int last_at, input bit gaps);
      start = 1; length = LEN_W'(len); sel_min = mn; sel_signed = sg;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < nb; i++) begin
         if (gaps && (i % 2 == 1)) begin
            in_valid = 0; in_data = 32'hFFFF_0000; in_last = 1;
            @(negedge clk);
         end
         in_valid = 1; in_data = vec[i]; in_last = (i + 1 == last_at);
         @(negedge clk);
      end
      in_valid = 0; in_last = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic load_a();
      vec[0] = 32'h3F80_0000; vec[1] = 32'hC040_0000;
      vec[2] = 32'h4000_0000; vec[3] = 32'h4040_0000;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int d0;
      int exp_i;
      logic [W-1:0] lf;
      repeat (3) @(negedge clk);
      chk("R1 ready", in_ready, 0);
      chk("R1 done", res_done, 0);
      chk("R1 index", res_index, 0);
      chk("R1 value", res_value, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R10 idle ready", in_ready, 0);

      load_a();
      run(4, 4, 0, 0, 4, 0);
      chk("R6 R5 absmax index", res_index, 2);
      chk("R6 absmax value", res_value, 32'hC040_0000);
      run(4, 4, 0, 1, 4, 0);
      chk("R7 signed max index", res_index, 4);
      run(4, 4, 1, 0, 4, 0);
      chk("R8 R4 absmin index", res_index, 1);
      chk("R8 absmin value", res_value, 32'h3F80_0000);
      run(4, 4, 1, 1, 4, 0);
      chk("R8 R7 signed min index", res_index, 2);

      vec[0] = 32'hBF80_0000; vec[1] = 32'hC000_0000; vec[2] = 32'hBF00_0000;
      run(3, 3, 0, 1, 0, 0);
      chk("R7 R9 neg max index", res_index, 3);
      chk("R7 neg max value", res_value, 32'hBF00_0000);
      run(3, 3, 1, 1, 0, 0);
      chk("R7 neg min index", res_index, 2);

      load_a();
      d0 = done_seen;
      run(2, 10, 0, 0, 2, 0);
      chk("R9 early last index", res_index, 2);
      chk("R9 single pulse", done_seen - d0, 1);
      chk("R10 ready after end", in_ready, 0);

      run(4, 4, 0, 1, 4, 1);
      chk("R3 gaps index", res_index, 4);

      vec[0] = 32'h4000_0000; vec[1] = 32'h4000_0000; vec[2] = 32'hC000_0000;
      run(3, 3, 0, 0, 3, 0);
      chk("R5 tie first index", res_index, 1);
      run(3, 3, 1, 0, 3, 0);
      chk("R5 tie min index", res_index, 1);

      vec[0] = 32'h4040_0000;
      run(1, 1, 1, 1, 0, 0);
      chk("R4 single index", res_index, 1);

      repeat (5) @(negedge clk);
      chk("R12 hold index", res_index, 1);
      chk("R12 hold value", res_value, 32'h4040_0000);
      chk("R10 hold ready", in_ready, 0);

      d0 = done_seen;
      run(0, 0, 0, 0, 0, 0);
      chk("R11 empty pulses", done_seen - d0, 1);
      chk("R11 empty index", res_index, 0);
      chk("R11 empty value", res_value, 0);

      // abandoned run, then restart
      load_a();
      d0 = done_seen;
      run(2, 5, 0, 0, 0, 0);
      chk("R2 abandoned no done", done_seen - d0, 0);
      chk("R2 ready still open", in_ready, 1);
      run(4, 4, 1, 1, 4, 0);
      chk("R2 restart index", res_index, 2);
      chk("R2 restart pulses", done_seen - d0, 1);

      // long pseudo-random vector
      lf = 32'h1357_9BDF;
      for (int i = 0; i < 200; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         vec[i] = {lf[31], 8'h80 + {4'h0, lf[3:0]}, lf[22:0]};
      end
      exp_i = 1;
      for (int i = 1; i < 200; i++)
         if (vec[i][30:0] > vec[exp_i-1][30:0]) exp_i = i + 1;
      run(200, 200, 0, 0, 200, 0);
      chk("R6 R9 long absmax index", res_index, exp_i);
      chk("R6 long absmax value", res_value, vec[exp_i-1]);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule